// File: doc/BRIEF.md
# Tick-Driven Watchdog with Unlock-Word Disable

This block guards a processor tile against a hung program. A slow tick (nominally one per millisecond) arrives as a one-cycle enable on the system clock. While the watchdog is armed, each tick lowers a 16-bit down-counter. If software does not refresh the counter before it runs out, the block raises a one-cycle reset request for the tile. The counter then reloads from the programmed timeout, so programmable timeouts run from one tick up to 65535 ticks.

Software talks to the block through a small word-wide register port. It can set the timeout, refresh ("kick") the counter, arm or disarm the watchdog, and read a cause flag that records whether a reset request was raised. Only one exact 32-bit key disarms the watchdog; any other value written to the control word arms it. The cause flag sits in the power-on reset domain, so the system reset that the watchdog itself triggers leaves it intact.

Register map (word address on `reg_addr`): 0 = timeout, 1 = kick, 2 = control, 3 = cause.

Top module: `tick_watchdog`

## Requirements
- R1: After power-on and system reset, `reset_req` is 0, the control read (address 2) returns 1 (armed), the timeout read (address 0) returns `DEF_TIMEOUT`, and the cause read (address 3) returns 0.
- R2: While armed, each sampled tick lowers the counter by one; with timeout N loaded and no refresh, `reset_req` is high in the clock cycle right after the edge that samples the Nth tick. Cycles without a tick do not count.
- R3: `reset_req` is high for one cycle per expiry, and the counter then reloads from the timeout register, so a further N ticks give another request.
- R4: A write to address 1 (any data) reloads the counter from the timeout register and leaves the timeout value unchanged.
- R5: Writing 0x0D15AB1E to address 2 disarms the watchdog: control bit 0 reads 0 and no tick raises `reset_req`.
- R6: Writing any other value to address 2 (including 0 and 0x0D15AB1F) arms the watchdog, reloads the counter, and sets control bit 0 to 1.
- R7: The cause flag (address 3, bit 0) becomes 1 in the same edge as `reset_req` rises. It survives system reset, stays 1 after a write with bit 0 = 0, and clears on a write with bit 0 = 1 or on power-on reset.
- R8: A write to address 0 stores only the low 16 bits as the timeout; the upper read-back bits are 0, and the write does not change the running count.
- R9: When a refresh write and a tick land on the same edge, the refresh wins: the counter reloads and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; clears the cause flag |
| rst_n | input | 1 | System reset, active low; clears everything but the cause flag |
| tick | input | 1 | Timebase tick, one-cycle enable (or level when `TICK_IS_PULSE` = 0) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address for writes |
| reg_wdata | input | 32 | Write data |
| rd_addr | input | 2 | Register word address for reads |
| rd_data | output | 32 | Read data, combinational from `rd_addr` |
| reset_req | output | 1 | Reset request pulse to the tile |

## Verification
The assertions assume that `tick` is a clean synchronous signal, that at most one register write lands per cycle, and that the register inputs are stable around the edge. The stimulus keeps to this by driving every input on the falling edge and by issuing one write per two-cycle slot. Ticks are given as single-cycle pulses with idle gaps, and once on the same edge as a refresh. A bench model predicts the cycle of every request and queues it, and the monitor pops one entry for each pulse it sees.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   typedef enum logic [1:0] {
      WDG_REG_TIMEOUT = 2'd0,
      WDG_REG_KICK    = 2'd1,
      WDG_REG_CTRL    = 2'd2,
      WDG_REG_CAUSE   = 2'd3
   } wdg_reg_e;

   localparam logic [31:0] WDG_UNLOCK_KEY = 32'h0D15_AB1E;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int          CNT_W        = 16,
   parameter int          DATA_W       = 32,
   parameter int          DEF_TIMEOUT  = 16'hFFFF,
   parameter bit          RESET_ENABLE = 1'b1,
   parameter logic [31:0] KEY          = WDG_UNLOCK_KEY
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [1:0]        addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [CNT_W-1:0]  timeout_o,
   output logic              armed_o,
   output logic              reload_o
);
   logic wr_to, wr_kick, wr_ctrl;
   logic [CNT_W-1:0] timeout_q;
   logic             armed_q;

   assign wr_to   = wr_i && (addr_i == WDG_REG_TIMEOUT);
   assign wr_kick = wr_i && (addr_i == WDG_REG_KICK);
   assign wr_ctrl = wr_i && (addr_i == WDG_REG_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timeout_q <= CNT_W'(DEF_TIMEOUT);
         armed_q   <= RESET_ENABLE;
      end else begin
         if (wr_to)   timeout_q <= wdata_i[CNT_W-1:0];
         if (wr_ctrl) armed_q   <= (wdata_i[31:0] != KEY);
      end
   end

   assign timeout_o = timeout_q;
   assign armed_o   = armed_q;
   assign reload_o  = wr_kick || wr_ctrl;

   AST_UNLOCK_DISARMS: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && wdata_i[31:0] == KEY) |=> !armed_q); // R5
   AST_OTHER_ARMS: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctrl && wdata_i[31:0] != KEY) |=> armed_q); // R6
   AST_KICK_KEEPS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n) wr_kick |=> $stable(timeout_q)); // R4
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int CNT_W       = 16,
   parameter int DEF_TIMEOUT = 16'hFFFF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             armed_i,
   input  logic             reload_i,
   input  logic [CNT_W-1:0] load_i,
   output logic             fire_o,
   output logic             fire_q_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
   logic [CNT_W-1:0] cnt_q;
   logic             fire_q;
   logic             last;

   assign last   = (cnt_q <= ONE);
   assign fire_o = armed_i && tick_i && !reload_i && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= CNT_W'(DEF_TIMEOUT);
         fire_q <= 1'b0;
      end else begin
         fire_q <= fire_o;
         if (reload_i)                 cnt_q <= load_i;
         else if (armed_i && tick_i)   cnt_q <= last ? load_i : cnt_q - ONE;
      end
   end

   assign fire_q_o = fire_q;

   AST_RELOAD_LOADS: assert property (@(posedge clk) disable iff (!rst_n) reload_i |=> cnt_q == $past(load_i)); // R4
   AST_DISARMED_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !armed_i |=> !fire_q); // R5
   AST_FIRE_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n) fire_q |-> $past(tick_i)); // R2
   AST_RELOAD_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n) reload_i |=> !fire_q); // R9
endmodule

// File: rtl/wdg_cause.sv
module wdg_cause (
   input  logic clk,
   input  logic por_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)      flag_q <= 1'b0;
      else if (set_i)  flag_q <= 1'b1;
      else if (clr_i)  flag_q <= 1'b0;
   end

   assign flag_o = flag_q;

   AST_CAUSE_SET: assert property (@(posedge clk) disable iff (!por_n) set_i |=> flag_q); // R7
   AST_CAUSE_CLEAR: assert property (@(posedge clk) disable iff (!por_n) (clr_i && !set_i) |=> !flag_q); // R7
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
   import wdg_pkg::*;
#(
   parameter int          CNT_W         = 16,
   parameter int          DATA_W        = 32,
   parameter int          DEF_TIMEOUT   = 16'hFFFF,
   parameter bit          RESET_ENABLE  = 1'b1,
   parameter bit          TICK_IS_PULSE = 1'b1,
   parameter logic [31:0] KEY           = WDG_UNLOCK_KEY
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              reg_wr,
   input  logic [1:0]        reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [1:0]        rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              reset_req
);
   localparam int PAD_W = DATA_W - CNT_W;

   if (CNT_W < 2 || CNT_W > 31) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (DATA_W < 32) begin : g_bad_data
      $error("DATA_W must hold the unlock key");
   end
   if (DEF_TIMEOUT < 1 || DEF_TIMEOUT >= (1 << CNT_W)) begin : g_bad_def
      $error("DEF_TIMEOUT does not fit CNT_W");
   end

   logic             tick_en;
   logic [CNT_W-1:0] timeout;
   logic             armed, reload, fire, fire_q, cause;

   if (TICK_IS_PULSE) begin : g_tick_pulse
      assign tick_en = tick;
   end else begin : g_tick_level
      logic tick_d;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) tick_d <= 1'b0;
         else        tick_d <= tick;
      end
      assign tick_en = tick && !tick_d;
   end

   wdg_regs #(
      .CNT_W(CNT_W), .DATA_W(DATA_W), .DEF_TIMEOUT(DEF_TIMEOUT),
      .RESET_ENABLE(RESET_ENABLE), .KEY(KEY)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
      .wdata_i(reg_wdata), .timeout_o(timeout), .armed_o(armed), .reload_o(reload)
   );

   wdg_counter #(.CNT_W(CNT_W), .DEF_TIMEOUT(DEF_TIMEOUT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .armed_i(armed),
      .reload_i(reload), .load_i(timeout), .fire_o(fire), .fire_q_o(fire_q)
   );

   wdg_cause u_cause (
      .clk(clk), .por_n(por_n), .set_i(fire),
      .clr_i(reg_wr && reg_addr == WDG_REG_CAUSE && reg_wdata[0]),
      .flag_o(cause)
   );

   assign reset_req = fire_q;

   always_comb begin
      unique case (rd_addr)
         WDG_REG_TIMEOUT: rd_data = {{PAD_W{1'b0}}, timeout};
         WDG_REG_CTRL:    rd_data = {{(DATA_W-1){1'b0}}, armed};
         WDG_REG_CAUSE:   rd_data = {{(DATA_W-1){1'b0}}, cause};
         default:         rd_data = '0;
      endcase
   end

   AST_REQ_MARKS_CAUSE: assert property (@(posedge clk) disable iff (!por_n || !rst_n) reset_req |-> cause); // R7
endmodule

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DEF_TO     = 5;

   logic        clk = 1'b0;
   logic        por_n = 1'b0, rst_n = 1'b0, tick = 1'b0, reg_wr = 1'b0;
   logic [1:0]  reg_addr = '0, rd_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] rd_data;
   logic        reset_req;

   int checks = 0, errors = 0, cyc = 0;
   int exp_q[$];
   int m_cnt, m_to;
   bit m_en;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   tick_watchdog #(.DEF_TIMEOUT(DEF_TO)) u_tick_watchdog (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rd_addr(rd_addr),
      .rd_data(rd_data), .reset_req(reset_req)
   );

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: every pulse must match the next queued cycle
   always @(negedge clk) begin
      if (reset_req) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R2/R3: actual pulse at %0d expected none", cyc);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (e != cyc) begin
               errors++;
               $display("FAIL R2/R3: actual pulse at %0d expected %0d", cyc, e);
            end
         end
      end
   end

   task automatic model_reset();
      m_en = 1'b1; m_to = DEF_TO; m_cnt = DEF_TO;
   endtask

   // one tick; optionally a kick on the same edge (R9)
   task automatic do_tick(input bit with_kick = 1'b0);
      @(negedge clk);
      tick = 1'b1;
      if (with_kick) begin
         reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h0;
         m_cnt = m_to;
      end else if (m_en) begin
         if (m_cnt <= 1) begin
            exp_q.push_back(cyc + 1);
            m_cnt = m_to;
         end else m_cnt--;
      end
      @(negedge clk);
      tick = 1'b0; reg_wr = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         do_tick();
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      case (a)
         2'd0: m_to = int'(d[15:0]);
         2'd1: m_cnt = m_to;
         2'd2: begin m_en = (d != 32'h0D15_AB1E); m_cnt = m_to; end
         default: ;
      endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   logic [31:0] v;
   bit done = 1'b0;

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      por_n = 1'b1; rst_n = 1'b1;
      // R1 reset state
      chk("R1 reset_req", reset_req, 0);
      rd(2'd0, v); chk("R1 timeout", v, DEF_TO);
      rd(2'd2, v); chk("R1 armed", v, 1);
      rd(2'd3, v); chk("R1 cause", v, 0);

      // R2 expiry after DEF_TO ticks, spaced ticks
      ticks(DEF_TO);
      rd(2'd3, v); chk("R7 cause set", v, 1);
      // R3 reload after expiry, second pulse
      ticks(DEF_TO);

      // R8 only low 16 bits stored
      wr(2'd0, 32'hABCD_0003);
      rd(2'd0, v); chk("R8 timeout readback", v, 32'h3);
      // R4 kick keeps timeout, reloads count
      wr(2'd1, 32'hFFFF_FFFF);
      rd(2'd0, v); chk("R4 timeout kept", v, 32'h3);
      ticks(2); wr(2'd1, 0); ticks(2);
      chk("R4 no pulse pending", exp_q.size(), 0);
      ticks(1);

      // R5 disarm with key
      wr(2'd2, 32'h0D15_AB1E);
      rd(2'd2, v); chk("R5 disarmed", v, 0);
      ticks(10);
      chk("R5 quiet", exp_q.size(), 0);
      // R6 near-miss arms
      wr(2'd2, 32'h0D15_AB1F);
      rd(2'd2, v); chk("R6 armed near-miss", v, 1);
      ticks(3);
      wr(2'd2, 32'h0D15_AB1E);
      wr(2'd2, 32'h0);
      rd(2'd2, v); chk("R6 armed by zero", v, 1);

      // R9 kick on the same edge as the final tick
      ticks(2);
      do_tick(1'b1);
      @(negedge clk);
      ticks(3);

      // R7 cause survives system reset, write 0 ignored, write 1 clears
      @(negedge clk); rst_n = 1'b0; model_reset();
      @(negedge clk); rst_n = 1'b1;
      rd(2'd3, v); chk("R7 survives sys reset", v, 1);
      rd(2'd0, v); chk("R1 timeout after sys reset", v, DEF_TO);
      wr(2'd3, 32'hFFFF_FFFE);
      rd(2'd3, v); chk("R7 write 0 ignored", v, 1);
      wr(2'd3, 32'h1);
      rd(2'd3, v); chk("R7 cleared by write", v, 0);
      ticks(DEF_TO);
      rd(2'd3, v); chk("R7 set again", v, 1);
      @(negedge clk); por_n = 1'b0; rst_n = 1'b0; model_reset();
      @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
      rd(2'd3, v); chk("R7 cleared by power-on", v, 0);

      repeat (4) @(negedge clk);
      chk("R2 all expected pulses seen", exp_q.size(), 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule